// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the wall-clock time and the calendar date as packed BCD fields, advancing once per pulse on a one-cycle `tick` input, which is typically a one-pulse-per-second strobe from a prescaler. It holds seconds, minutes, hours, date, month, a two-digit year and a three-bit day of week. Every field is presented in parallel on its own output, straight from the counting registers.

A host sets the time through a simple load port: it selects one field, presents a byte and pulses `wr_en`. After reset the counter stays frozen until the first such write, so a freshly powered part never runs with a time nobody set. Hours can be kept in 24-hour form or in 12-hour form with a PM flag, chosen by the top bit of the hour field. Month lengths and February in leap years are handled, and carries ripple from seconds up to the year within a single tick.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 8'h00, date and month read 8'h01, and day of week reads 0.
- R2: After reset no field advances on `tick` until the first `wr_en` pulse to any field select; from that write on, every `tick` advances the time.
- R3: Seconds and minutes count in BCD from 00 to 59; seconds at 59 wraps to 00 and advances minutes, minutes at 59 wraps to 00 and advances hours.
- R4: With hour bit 7 at 0 (24-hour form, tens in bits 5:4, units in bits 3:0) hours count 00 to 23; a tick at 23:59:59 gives 00:00:00 and advances the date.
- R5: With hour bit 7 at 1 (12-hour form, PM flag in bit 5, tens in bit 4, units in bits 3:0) hours count 12, 01 … 11; the PM flag toggles on 11 to 12, and the date advances only on 11 PM to 12 AM.
- R6: The date wraps to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February.
- R7: February ends after day 29 when the BCD year is divisible by 4 (00 included) and after day 28 otherwise.
- R8: After the last day of month 12 the month returns to 01 and the year advances; year 99 wraps to 00.
- R9: Day of week advances with the date at every day end and cycles 0,1,2,3,4,5,6,0.
- R10: `wr_sel` codes 0 to 6 select seconds, minutes, hours, date, month, year and day of week; the written byte is masked with 8'h7F, 8'h7F, 8'hBF, 8'h3F, 8'h1F, 8'hFF and 3'h7 and appears on the field output after the next clock edge. A write cycle discards any tick in that same cycle, so no field advances then.
- R11: Without `tick` and without `wr_en`, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle advance strobe (one per second) |
| wr_en | input | 1 | Load strobe for the selected field |
| wr_sel | input | 3 | Field select for a load |
| wr_data | input | 8 | Packed BCD value to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with format bit and PM flag |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| dow_o | output | 3 | Day of week, 0 to 6 |

## Verification
The hardest states to reach are the rare carry chains: a month end, a February in leap and common years, and the year end, which would take millions of ticks from reset. The bench reaches each one by loading every field through the write port to one second before the boundary and then applying a single tick, so the full ripple from seconds to year is seen in one cycle. The tick-and-write collision is driven by asserting both strobes in the same cycle with seconds at 59, so a wrongly honoured tick shows up as a minute change.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int FIELD_W = 8;
  localparam int DOW_W   = 3;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_YEAR  = 3'd5,
    FLD_DOW   = 3'd6
  } fld_e;

  // Two-digit BCD increment without range limit.
  function automatic logic [FIELD_W-1:0] bcd_inc8(input logic [FIELD_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year divisible by 4: ten is 2 mod 4, so test (2*tens + units) mod 4.
  function automatic logic leap_bcd(input logic [FIELD_W-1:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [FIELD_W-1:0] month_last(input logic [FIELD_W-1:0] mo,
                                                    input logic [FIELD_W-1:0] yr);
    case (mo)
      8'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_wrap_counter.sv
module bcd_wrap_counter
  import bcd_rtc_pkg::*;
#(
  parameter logic [FIELD_W-1:0] FIRST = 8'h00,
  parameter logic [FIELD_W-1:0] LAST  = 8'h59,
  parameter logic [FIELD_W-1:0] MASK  = 8'h7F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld,
  input  logic [FIELD_W-1:0] ld_val,
  input  logic               inc,
  output logic [FIELD_W-1:0] q,
  output logic               at_last
);

  always_ff @(posedge clk) begin
    if (rst)       q <= FIRST;
    else if (ld)   q <= ld_val & MASK;
    else if (inc)  q <= (q == LAST) ? FIRST : bcd_inc8(q);
  end

  assign at_last = (q == LAST);

endmodule

// File: rtl/bcd_hour_counter.sv
module bcd_hour_counter
  import bcd_rtc_pkg::*;
#(
  parameter logic [FIELD_W-1:0] MASK = 8'hBF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld,
  input  logic [FIELD_W-1:0] ld_val,
  input  logic               inc,
  output logic [FIELD_W-1:0] q,
  output logic               day_end
);

  logic               mode12;
  logic [FIELD_W-1:0] inc24, inc12, nxt;

  assign mode12 = q[7];
  assign inc24  = bcd_inc8({2'b00, q[5:0]});
  assign inc12  = bcd_inc8({3'b000, q[4:0]});

  always_comb begin
    if (!mode12) begin
      if (q[5:0] == 6'h23) nxt = 8'h00;
      else                 nxt = {2'b00, inc24[5:0]};
    end else begin
      if (q[4:0] == 5'h12)      nxt = {1'b1, 1'b0, q[5], 5'h01};
      else if (q[4:0] == 5'h11) nxt = {1'b1, 1'b0, ~q[5], 5'h12};
      else                      nxt = {1'b1, 1'b0, q[5], inc12[4:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= 8'h00;
    else if (ld)  q <= ld_val & MASK;
    else if (inc) q <= nxt;
  end

  assign day_end = mode12 ? (q[5] && (q[4:0] == 5'h11)) : (q[5:0] == 6'h23);

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_rtc_pkg::*;
#(
  parameter logic [FIELD_W-1:0] DATE_MASK  = 8'h3F,
  parameter logic [FIELD_W-1:0] MONTH_MASK = 8'h1F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_date,
  input  logic               ld_month,
  input  logic [FIELD_W-1:0] ld_val,
  input  logic               day_inc,
  input  logic [FIELD_W-1:0] year_q,
  output logic [FIELD_W-1:0] date_q,
  output logic [FIELD_W-1:0] month_q,
  output logic               year_carry
);

  logic month_end;

  assign month_end  = (date_q == month_last(month_q, year_q));
  assign year_carry = day_inc && month_end && (month_q == 8'h12);

  always_ff @(posedge clk) begin
    if (rst)               date_q <= 8'h01;
    else if (ld_date)      date_q <= ld_val & DATE_MASK;
    else if (day_inc)      date_q <= month_end ? 8'h01 : bcd_inc8(date_q);
  end

  always_ff @(posedge clk) begin
    if (rst)                       month_q <= 8'h01;
    else if (ld_month)             month_q <= ld_val & MONTH_MASK;
    else if (day_inc && month_end) month_q <= (month_q == 8'h12) ? 8'h01 : bcd_inc8(month_q);
  end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import bcd_rtc_pkg::*;
#(
  parameter int DOW_LAST = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] sec_o,
  output logic [FIELD_W-1:0] min_o,
  output logic [FIELD_W-1:0] hour_o,
  output logic [FIELD_W-1:0] date_o,
  output logic [FIELD_W-1:0] month_o,
  output logic [FIELD_W-1:0] year_o,
  output logic [DOW_W-1:0]   dow_o
);

  localparam logic [DOW_W-1:0] DOW_MAX = DOW_W'(DOW_LAST);

  logic running;
  logic adv, min_inc, hour_inc, day_inc, year_inc;
  logic sec_last, min_last, day_end, year_last_unused;
  logic ld_sec, ld_min, ld_hour, ld_date, ld_month, ld_year, ld_dow;

  assign ld_sec   = wr_en && (wr_sel == FLD_SEC);
  assign ld_min   = wr_en && (wr_sel == FLD_MIN);
  assign ld_hour  = wr_en && (wr_sel == FLD_HOUR);
  assign ld_date  = wr_en && (wr_sel == FLD_DATE);
  assign ld_month = wr_en && (wr_sel == FLD_MONTH);
  assign ld_year  = wr_en && (wr_sel == FLD_YEAR);
  assign ld_dow   = wr_en && (wr_sel == FLD_DOW);

  // Counting starts with the first host load of any field.
  always_ff @(posedge clk) begin
    if (rst)        running <= 1'b0;
    else if (wr_en) running <= 1'b1;
  end

  assign adv      = running && tick && !wr_en;
  assign min_inc  = adv && sec_last;
  assign hour_inc = min_inc && min_last;
  assign day_inc  = hour_inc && day_end;

  bcd_wrap_counter #(.FIRST(8'h00), .LAST(8'h59), .MASK(8'h7F)) u_sec (
    .clk(clk), .rst(rst), .ld(ld_sec), .ld_val(wr_data), .inc(adv),
    .q(sec_o), .at_last(sec_last));

  bcd_wrap_counter #(.FIRST(8'h00), .LAST(8'h59), .MASK(8'h7F)) u_min (
    .clk(clk), .rst(rst), .ld(ld_min), .ld_val(wr_data), .inc(min_inc),
    .q(min_o), .at_last(min_last));

  bcd_hour_counter #(.MASK(8'hBF)) u_hour (
    .clk(clk), .rst(rst), .ld(ld_hour), .ld_val(wr_data), .inc(hour_inc),
    .q(hour_o), .day_end(day_end));

  bcd_calendar #(.DATE_MASK(8'h3F), .MONTH_MASK(8'h1F)) u_cal (
    .clk(clk), .rst(rst), .ld_date(ld_date), .ld_month(ld_month), .ld_val(wr_data),
    .day_inc(day_inc), .year_q(year_o), .date_q(date_o), .month_q(month_o),
    .year_carry(year_inc));

  bcd_wrap_counter #(.FIRST(8'h00), .LAST(8'h99), .MASK(8'hFF)) u_year (
    .clk(clk), .rst(rst), .ld(ld_year), .ld_val(wr_data), .inc(year_inc),
    .q(year_o), .at_last(year_last_unused));

  always_ff @(posedge clk) begin
    if (rst)          dow_o <= '0;
    else if (ld_dow)  dow_o <= wr_data[DOW_W-1:0];
    else if (day_inc) dow_o <= (dow_o == DOW_MAX) ? '0 : dow_o + 1'b1;
  end

endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic [2:0] dow_o
);

  logic armed, seen_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      seen_wr <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (wr_en) seen_wr <= 1'b1;
    end
  end

  assert_hold_until_write_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && !seen_wr) |-> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
                             && $stable(date_o) && $stable(dow_o)));

  assert_sec_step_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && seen_wr && tick && !wr_en && (sec_o[3:0] < 4'd9))
      |=> (sec_o == $past(sec_o) + 8'd1) && $stable(min_o));

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && seen_wr && tick && !wr_en && (sec_o == 8'h59))
      |=> (sec_o == 8'h00) && (min_o != $past(min_o)));

  assert_load_sec_R10: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_en && (wr_sel == 3'd0)) |=> (sec_o == ($past(wr_data) & 8'h7F)));

  assert_load_blocks_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_en && (wr_sel != 3'd1)) |=> $stable(min_o));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (armed && !tick && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
      && $stable(date_o) && $stable(month_o) && $stable(year_o) && $stable(dow_o)));

  assert_dow_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && !(wr_en && (wr_sel == 3'd6)) && (dow_o <= 3'd6))
      |=> (dow_o == $past(dow_o)) ||
          (dow_o == (($past(dow_o) == 3'd6) ? 3'd0 : $past(dow_o) + 3'd1)));

endmodule

bind bcd_rtc_core bcd_rtc_checker u_chk (.*);

// File: tb/sim_bcd_rtc_core.sv
module sim_bcd_rtc_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
  logic [2:0] dow_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bcd_rtc_core u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .dow_o(dow_o));

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d, input bit with_tick);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] hr, input logic [7:0] mn, input logic [7:0] sc,
                         input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr,
                         input logic [2:0] dw);
    wr(3'd2, hr, 0); wr(3'd1, mn, 0); wr(3'd0, sc, 0);
    wr(3'd5, yr, 0); wr(3'd4, mo, 0); wr(3'd3, dt, 0);
    wr(3'd6, {5'd0, dw}, 0);
  endtask

  task automatic t_reset();
    chk("R1", "sec", sec_o, 8'h00);     chk("R1", "min", min_o, 8'h00);
    chk("R1", "hour", hour_o, 8'h00);   chk("R1", "date", date_o, 8'h01);
    chk("R1", "month", month_o, 8'h01); chk("R1", "year", year_o, 8'h00);
    chk("R1", "dow", {5'd0, dow_o}, 8'h00);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) pulse_tick();
    chk("R2", "sec before write", sec_o, 8'h00);
    wr(3'd6, 8'h03, 0);
    chk("R10", "dow load", {5'd0, dow_o}, 8'h03);
    pulse_tick();
    chk("R2", "sec after write", sec_o, 8'h01);
    pulse_tick();
    chk("R3", "sec step", sec_o, 8'h02);
  endtask

  task automatic t_load();
    wr(3'd0, 8'hFF, 0);
    chk("R10", "sec mask", sec_o, 8'h7F);
    wr(3'd2, 8'hFF, 0);
    chk("R10", "hour mask", hour_o, 8'hBF);
    set_all(8'h05, 8'h20, 8'h59, 8'h10, 8'h06, 8'h30, 3'd2);
    wr(3'd0, 8'h30, 1);
    chk("R10", "collision sec", sec_o, 8'h30);
    chk("R10", "collision min", min_o, 8'h20);
  endtask

  task automatic t_quiet();
    repeat (5) @(negedge clk);
    chk("R11", "sec idle", sec_o, 8'h30);
    chk("R11", "min idle", min_o, 8'h20);
  endtask

  task automatic t_minutes();
    set_all(8'h00, 8'h09, 8'h59, 8'h10, 8'h06, 8'h30, 3'd2);
    pulse_tick();
    chk("R3", "sec wrap", sec_o, 8'h00);
    chk("R3", "min 09->10", min_o, 8'h10);
    set_all(8'h09, 8'h59, 8'h59, 8'h10, 8'h06, 8'h30, 3'd2);
    pulse_tick();
    chk("R3", "min wrap", min_o, 8'h00);
    chk("R4", "hour 09->10", hour_o, 8'h10);
  endtask

  task automatic t_day24();
    set_all(8'h23, 8'h59, 8'h59, 8'h15, 8'h03, 8'h30, 3'd6);
    pulse_tick();
    chk("R4", "hour 23->00", hour_o, 8'h00);
    chk("R4", "date step", date_o, 8'h16);
    chk("R9", "dow 6->0", {5'd0, dow_o}, 8'h00);
    set_all(8'h13, 8'h59, 8'h59, 8'h15, 8'h03, 8'h30, 3'd1);
    pulse_tick();
    chk("R4", "hour 13->14", hour_o, 8'h14);
    chk("R4", "date held", date_o, 8'h15);
  endtask

  task automatic t_day12();
    set_all(8'hB1, 8'h59, 8'h59, 8'h15, 8'h03, 8'h30, 3'd3);
    pulse_tick();
    chk("R5", "11PM->12AM", hour_o, 8'h92);
    chk("R5", "date at midnight", date_o, 8'h16);
    chk("R9", "dow 3->4", {5'd0, dow_o}, 8'h04);
    set_all(8'h91, 8'h59, 8'h59, 8'h15, 8'h03, 8'h30, 3'd3);
    pulse_tick();
    chk("R5", "11AM->12PM", hour_o, 8'hB2);
    chk("R5", "date at noon", date_o, 8'h15);
    set_all(8'hB2, 8'h59, 8'h59, 8'h15, 8'h03, 8'h30, 3'd3);
    pulse_tick();
    chk("R5", "12PM->1PM", hour_o, 8'hA1);
    set_all(8'h89, 8'h59, 8'h59, 8'h15, 8'h03, 8'h30, 3'd3);
    pulse_tick();
    chk("R5", "9AM->10AM", hour_o, 8'h90);
  endtask

  task automatic t_months();
    set_all(8'h23, 8'h59, 8'h59, 8'h30, 8'h04, 8'h30, 3'd0);
    pulse_tick();
    chk("R6", "Apr30 date", date_o, 8'h01);
    chk("R6", "Apr30 month", month_o, 8'h05);
    set_all(8'h23, 8'h59, 8'h59, 8'h30, 8'h05, 8'h30, 3'd0);
    pulse_tick();
    chk("R6", "May30 date", date_o, 8'h31);
    set_all(8'h23, 8'h59, 8'h59, 8'h30, 8'h11, 8'h30, 3'd0);
    pulse_tick();
    chk("R6", "Nov30 month", month_o, 8'h12);
  endtask

  task automatic t_feb();
    set_all(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h24, 3'd0);
    pulse_tick();
    chk("R7", "Feb28 leap 24", date_o, 8'h29);
    set_all(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h00, 3'd0);
    pulse_tick();
    chk("R7", "Feb28 leap 00", date_o, 8'h29);
    set_all(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h10, 3'd0);
    pulse_tick();
    chk("R7", "Feb28 common 10 date", date_o, 8'h01);
    chk("R7", "Feb28 common 10 month", month_o, 8'h03);
    set_all(8'h23, 8'h59, 8'h59, 8'h29, 8'h02, 8'h96, 3'd0);
    pulse_tick();
    chk("R7", "Feb29 leap 96 month", month_o, 8'h03);
  endtask

  task automatic t_year();
    set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99, 3'd5);
    pulse_tick();
    chk("R8", "NY date", date_o, 8'h01);
    chk("R8", "NY month", month_o, 8'h01);
    chk("R8", "year 99->00", year_o, 8'h00);
    chk("R3", "NY sec", sec_o, 8'h00);
    set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h49, 3'd5);
    pulse_tick();
    chk("R8", "year 49->50", year_o, 8'h50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hold();
    t_load();
    t_quiet();
    t_minutes();
    t_day24();
    t_day12();
    t_months();
    t_feb();
    t_year();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule